// File: doc/BRIEF.md
# Shared Control Register Hub

This block is a central register unit shared by several processor cores. Each core has its own request lines and its own response-valid line. Requests carry a read/write flag, a 12-bit register address, write data and the privilege level of the access. The hub serves one request per cycle and picks among competing cores in rotating order. It returns read data, an error flag and an exception flag to the requesting core one cycle after it accepts the request.

The hub holds a free-running wall clock and pushes its value to all cores at a fixed interval. It latches the interrupt source lines every cycle. Each core's interrupt output is raised when any latched source is also set in that core's enable mask. A write to the reset register issues a one-cycle soft-reset pulse. Memory-map and I/O-map section registers are written into a staging copy. The live map, which drives the broadcast ports, is replaced as a whole only when the matching update register is written. A one-cycle commit strobe tells the listeners to sample the new map.

Top module: `ctrl_reg_hub`

## Requirements
- R1: When several cores request together, one request is accepted per cycle, starting the search at the core after the last one accepted (core 0 first after reset). The response (rsp_valid_o one-hot) goes only to the accepted core, in the cycle after acceptance.
- R2: Any access whose privilege is not machine level (priv value 2'b11) completes with rsp_err_o=1, returns data 0 and changes no state.
- R3: The following complete with rsp_err_o=1 and change no state: an address that maps to no register, a write to the wall clock (0x701), and a write to a pending register (0x7c1+2n).
- R4: Memory section s (s below MEM_SECTS) uses 0x7a0+4s for the base, +1 for the mask and +2 for the physical base. Offset +3 is unmapped except 0x7af. Reads return the staged value. The live mem_* outputs change only when 0x7af is written, which also pulses mem_commit_o for one cycle. 0x7af reads as 0.
- R5: I/O section s uses 0x7b0+4s for the base and +1 for the mask. Offsets +2 and +3 are unmapped except 0x7bf. Reads return the staged value. The live io_* outputs change only when 0x7bf is written, which also pulses io_commit_o. 0x7bf reads as 0.
- R6: After reset, section 0 of both maps (staged and live) holds the parameter defaults. All other sections, the enable masks, tohost and fromhost are zero.
- R7: Sources are latched every cycle. The enable mask of core n is at 0x7c0+2n and its pending value is at 0x7c1+2n (read-only), for n below NUM_CORES. The pending value equals the latched sources AND the enable mask, and core_irq_o[n] is the OR of that value.
- R8: The wall clock starts at 0 and rises by one every cycle. A read of 0x701 returns the live count. Every TICK_PERIOD cycles, time_tick_o pulses and time_value_o is 20 higher than at the previous pulse (default TICK_PERIOD=20).
- R9: A write of any value to 0x782 pulses soft_rst_o for one cycle. 0x782 reads as 0.
- R10: tohost (0x780) and fromhost (0x781) read back what was written. A write of a non-zero value to fromhost sets rsp_exc_o in that response. Writing zero there, or writing anything to tohost, does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | NUM_CORES | Per-core request present |
| req_ready_o | output | NUM_CORES | Request accepted this cycle |
| req_write_i | input | NUM_CORES | Per-core write flag |
| req_addr_i | input | NUM_CORES*12 | Per-core register address |
| req_wdata_i | input | NUM_CORES*DATA_W | Per-core write data |
| req_priv_i | input | NUM_CORES*2 | Per-core privilege level |
| rsp_valid_o | output | NUM_CORES | One-hot response strobe |
| rsp_rdata_o | output | DATA_W | Read data of the response |
| rsp_err_o | output | 1 | Access refused |
| rsp_exc_o | output | 1 | Non-zero fromhost write |
| irq_src_i | input | NUM_IRQ | Interrupt source lines |
| core_irq_o | output | NUM_CORES | Per-core interrupt request |
| soft_rst_o | output | 1 | Soft-reset pulse |
| time_tick_o | output | 1 | Wall-clock broadcast strobe |
| time_value_o | output | DATA_W | Broadcast wall-clock value |
| mem_commit_o | output | 1 | Memory map committed |
| mem_base_o | output | MEM_SECTS*DATA_W | Live memory bases |
| mem_mask_o | output | MEM_SECTS*DATA_W | Live memory masks |
| mem_phys_o | output | MEM_SECTS*DATA_W | Live physical bases |
| io_commit_o | output | 1 | I/O map committed |
| io_base_o | output | IO_SECTS*DATA_W | Live I/O bases |
| io_mask_o | output | IO_SECTS*DATA_W | Live I/O masks |

## Verification
A staged value leaking into the live map shows on the mem_*/io_* broadcast ports in the cycle after the section write, before any update write and with no commit strobe. A wrong round-robin pointer shows as responses in the wrong core order during the first burst of simultaneous requests. A bad decode or a missing privilege check shows either as an error flag on a legal access or as a later read-back that does not match. Wall-clock faults show at the second broadcast strobe, as wrong spacing or a wrong value step.

// File: rtl/hub_pkg.sv
package hub_pkg;
   localparam int AW = 12;
   localparam logic [1:0]    PRIV_M     = 2'b11;
   localparam logic [AW-1:0] A_TIME     = 12'h701;
   localparam logic [AW-1:0] A_TOHOST   = 12'h780;
   localparam logic [AW-1:0] A_FROMHOST = 12'h781;
   localparam logic [AW-1:0] A_RESET    = 12'h782;
   localparam logic [AW-1:0] A_MEM_UPD  = 12'h7af;
   localparam logic [AW-1:0] A_IO_UPD   = 12'h7bf;
   localparam logic [7:0]    PG_MEM     = 8'h7a;
   localparam logic [7:0]    PG_IO      = 8'h7b;
   localparam logic [7:0]    PG_INT     = 8'h7c;

   typedef enum logic [3:0] {
      K_NONE, K_TIME, K_TOHOST, K_FROMHOST, K_RESET,
      K_MEM, K_MEMUPD, K_IO, K_IOUPD, K_INTEN, K_INTPEND
   } reg_kind_e;
endpackage

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o,
   output logic [(N>1?$clog2(N):1)-1:0] gidx_o
);
   localparam int CW = (N > 1) ? $clog2(N) : 1;

   logic [CW-1:0] ptr_q;
   logic          found;

   always_comb begin
      grant_o = '0;
      gidx_o  = '0;
      found   = 1'b0;
      for (int i = 0; i < N; i++) begin
         int idx;
         idx = (int'(ptr_q) + 1 + i) % N;
         if (!found && req_i[idx]) begin
            grant_o[idx] = 1'b1;
            gidx_o       = CW'(idx);
            found        = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ptr_q <= CW'(N - 1);
      else if (found) ptr_q <= gidx_o;
   end

   a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   a_r1_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o & ~req_i) == '0);
endmodule

// File: rtl/wall_timer.sv
module wall_timer #(
   parameter int DW     = 64,
   parameter int PERIOD = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [DW-1:0] cnt_o,
   output logic          tick_o,
   output logic [DW-1:0] tick_val_o
);
   localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   if (PERIOD < 2) begin : g_bad_period
      $error("wall_timer: PERIOD must be at least 2");
   end

   logic [PW-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o      <= '0;
         div_q      <= '0;
         tick_o     <= 1'b0;
         tick_val_o <= '0;
      end else begin
         cnt_o  <= cnt_o + 1'b1;
         tick_o <= 1'b0;
         if (div_q == PW'(PERIOD - 1)) begin
            div_q      <= '0;
            tick_o     <= 1'b1;
            tick_val_o <= cnt_o + 1'b1;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt_o == $past(cnt_o) + 1'b1);
   a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/map_bank.sv
module map_bank #(
   parameter int          DW      = 64,
   parameter int          SECTS   = 4,
   parameter int          FIELDS  = 3,
   parameter logic [DW-1:0] INIT_F0 = '0,
   parameter logic [DW-1:0] INIT_F1 = '0,
   parameter logic [DW-1:0] INIT_F2 = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_i,
   input  logic [1:0]               sect_i,
   input  logic [1:0]               fld_i,
   input  logic [DW-1:0]            wdata_i,
   input  logic                     commit_i,
   output logic [DW-1:0]            rd_data_o,
   output logic [SECTS*FIELDS*DW-1:0] live_o,
   output logic                     commit_o
);
   if (SECTS < 1 || SECTS > 4 || FIELDS < 1 || FIELDS > 3) begin : g_bad_shape
      $error("map_bank: SECTS must be 1..4 and FIELDS 1..3");
   end

   logic [DW-1:0] stage_q [SECTS][FIELDS];
   logic [DW-1:0] live_q  [SECTS][FIELDS];

   function automatic logic [DW-1:0] reset_val(int s, int f);
      if (s != 0)  return '0;
      if (f == 0)  return INIT_F0;
      if (f == 1)  return INIT_F1;
      return INIT_F2;
   endfunction

   always_ff @(posedge clk) begin
      commit_o <= rst_n && commit_i;
      for (int s = 0; s < SECTS; s++) begin
         for (int f = 0; f < FIELDS; f++) begin
            if (!rst_n) begin
               stage_q[s][f] <= reset_val(s, f);
               live_q[s][f]  <= reset_val(s, f);
            end else begin
               if (wr_i && int'(sect_i) == s && int'(fld_i) == f)
                  stage_q[s][f] <= wdata_i;
               if (commit_i)
                  live_q[s][f] <= stage_q[s][f];
            end
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      for (int s = 0; s < SECTS; s++)
         for (int f = 0; f < FIELDS; f++)
            if (int'(sect_i) == s && int'(fld_i) == f)
               rd_data_o = stage_q[s][f];
   end

   for (genvar s = 0; s < SECTS; s++) begin : g_sect
      for (genvar f = 0; f < FIELDS; f++) begin : g_fld
         assign live_o[(s*FIELDS+f)*DW +: DW] = live_q[s][f];
      end
   end

   // R4 and R5: the live map holds unless a commit was requested
   a_r4_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(live_o));
endmodule

// File: rtl/irq_unit.sv
module irq_unit #(
   parameter int N    = 4,
   parameter int NIRQ = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NIRQ-1:0] src_i,
   input  logic            wr_i,
   input  logic [2:0]      core_i,
   input  logic [NIRQ-1:0] wdata_i,
   output logic [NIRQ-1:0] en_o,
   output logic [NIRQ-1:0] pend_o,
   output logic [N-1:0]    core_irq_o
);
   logic [NIRQ-1:0] src_q;
   logic [NIRQ-1:0] en_q [N];

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_i;
      for (int n = 0; n < N; n++) begin
         if (!rst_n)                         en_q[n] <= '0;
         else if (wr_i && int'(core_i) == n) en_q[n] <= wdata_i;
      end
   end

   for (genvar n = 0; n < N; n++) begin : g_core
      assign core_irq_o[n] = |(src_q & en_q[n]);
   end

   always_comb begin
      en_o   = '0;
      pend_o = '0;
      for (int n = 0; n < N; n++)
         if (int'(core_i) == n) begin
            en_o   = en_q[n];
            pend_o = src_q & en_q[n];
         end
   end

   a_r7_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
      (core_irq_o != '0) |-> (src_q != '0));
endmodule

// File: rtl/ctrl_reg_hub.sv
module ctrl_reg_hub
   import hub_pkg::*;
#(
   parameter int          NUM_CORES     = 4,
   parameter int          DATA_W        = 64,
   parameter int          NUM_IRQ       = 64,
   parameter int          MEM_SECTS     = 4,
   parameter int          IO_SECTS      = 4,
   parameter int          TICK_PERIOD   = 20,
   parameter logic [DATA_W-1:0] INIT_MEM_BASE = 64'h0000_0000_8000_0000,
   parameter logic [DATA_W-1:0] INIT_MEM_MASK = 64'h0000_0000_0FFF_FFFF,
   parameter logic [DATA_W-1:0] INIT_MEM_PHYS = 64'h0000_0000_0000_0000,
   parameter logic [DATA_W-1:0] INIT_IO_BASE  = 64'h0000_0000_6000_0000,
   parameter logic [DATA_W-1:0] INIT_IO_MASK  = 64'h0000_0000_0000_FFFF
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CORES-1:0]          req_valid_i,
   output logic [NUM_CORES-1:0]          req_ready_o,
   input  logic [NUM_CORES-1:0]          req_write_i,
   input  logic [NUM_CORES*12-1:0]       req_addr_i,
   input  logic [NUM_CORES*DATA_W-1:0]   req_wdata_i,
   input  logic [NUM_CORES*2-1:0]        req_priv_i,
   output logic [NUM_CORES-1:0]          rsp_valid_o,
   output logic [DATA_W-1:0]             rsp_rdata_o,
   output logic                          rsp_err_o,
   output logic                          rsp_exc_o,
   input  logic [NUM_IRQ-1:0]            irq_src_i,
   output logic [NUM_CORES-1:0]          core_irq_o,
   output logic                          soft_rst_o,
   output logic                          time_tick_o,
   output logic [DATA_W-1:0]             time_value_o,
   output logic                          mem_commit_o,
   output logic [MEM_SECTS*DATA_W-1:0]   mem_base_o,
   output logic [MEM_SECTS*DATA_W-1:0]   mem_mask_o,
   output logic [MEM_SECTS*DATA_W-1:0]   mem_phys_o,
   output logic                          io_commit_o,
   output logic [IO_SECTS*DATA_W-1:0]    io_base_o,
   output logic [IO_SECTS*DATA_W-1:0]    io_mask_o
);
   localparam int CW      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
   localparam int MEM_FLD = 3;
   localparam int IO_FLD  = 2;

   if (NUM_CORES < 1 || NUM_CORES > 8) begin : g_bad_cores
      $error("ctrl_reg_hub: NUM_CORES must be 1..8");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > DATA_W) begin : g_bad_irq
      $error("ctrl_reg_hub: NUM_IRQ must be 1..DATA_W");
   end
   if (MEM_SECTS > 4 || IO_SECTS > 4 || MEM_SECTS < 1 || IO_SECTS < 1) begin : g_bad_sects
      $error("ctrl_reg_hub: section counts must be 1..4");
   end

   // ---------------- arbitration and request select ----------------
   logic [NUM_CORES-1:0] grant;
   logic [CW-1:0]        gidx;
   logic                 any_grant;

   rr_arbiter #(.N(NUM_CORES)) u_arb (
      .clk(clk), .rst_n(rst_n), .req_i(req_valid_i),
      .grant_o(grant), .gidx_o(gidx)
   );

   assign req_ready_o = grant;
   assign any_grant   = |grant;

   logic [AW-1:0]     s_addr;
   logic [DATA_W-1:0] s_wdata;
   logic [1:0]        s_priv;
   logic              s_write;

   always_comb begin
      s_addr  = req_addr_i[int'(gidx)*AW +: AW];
      s_wdata = req_wdata_i[int'(gidx)*DATA_W +: DATA_W];
      s_priv  = req_priv_i[int'(gidx)*2 +: 2];
      s_write = req_write_i[gidx];
   end

   // ---------------- address decode ----------------
   reg_kind_e kind;
   logic      err;
   logic      wr_ok;

   always_comb begin
      kind = K_NONE;
      if (s_addr == A_TIME)          kind = K_TIME;
      else if (s_addr == A_TOHOST)   kind = K_TOHOST;
      else if (s_addr == A_FROMHOST) kind = K_FROMHOST;
      else if (s_addr == A_RESET)    kind = K_RESET;
      else if (s_addr == A_MEM_UPD)  kind = K_MEMUPD;
      else if (s_addr == A_IO_UPD)   kind = K_IOUPD;
      else if (s_addr[11:4] == PG_MEM && s_addr[1:0] != 2'd3
               && int'(s_addr[3:2]) < MEM_SECTS)
         kind = K_MEM;
      else if (s_addr[11:4] == PG_IO && int'(s_addr[1:0]) < IO_FLD
               && int'(s_addr[3:2]) < IO_SECTS)
         kind = K_IO;
      else if (s_addr[11:4] == PG_INT && int'(s_addr[3:1]) < NUM_CORES)
         kind = s_addr[0] ? K_INTPEND : K_INTEN;

      err = (s_priv != PRIV_M) || (kind == K_NONE)
         || (s_write && (kind == K_TIME || kind == K_INTPEND));
      wr_ok = any_grant && s_write && !err;
   end

   // ---------------- register file pieces ----------------
   logic [DATA_W-1:0] time_cnt;
   logic [DATA_W-1:0] tohost_q, fromhost_q;
   logic [DATA_W-1:0] mem_rd, io_rd;
   logic [MEM_SECTS*MEM_FLD*DATA_W-1:0] mem_live;
   logic [IO_SECTS*IO_FLD*DATA_W-1:0]   io_live;
   logic [NUM_IRQ-1:0] en_rd, pend_rd;

   wall_timer #(.DW(DATA_W), .PERIOD(TICK_PERIOD)) u_timer (
      .clk(clk), .rst_n(rst_n), .cnt_o(time_cnt),
      .tick_o(time_tick_o), .tick_val_o(time_value_o)
   );

   map_bank #(.DW(DATA_W), .SECTS(MEM_SECTS), .FIELDS(MEM_FLD),
              .INIT_F0(INIT_MEM_BASE), .INIT_F1(INIT_MEM_MASK),
              .INIT_F2(INIT_MEM_PHYS)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr_ok && kind == K_MEM), .sect_i(s_addr[3:2]), .fld_i(s_addr[1:0]),
      .wdata_i(s_wdata), .commit_i(wr_ok && kind == K_MEMUPD),
      .rd_data_o(mem_rd), .live_o(mem_live), .commit_o(mem_commit_o)
   );

   map_bank #(.DW(DATA_W), .SECTS(IO_SECTS), .FIELDS(IO_FLD),
              .INIT_F0(INIT_IO_BASE), .INIT_F1(INIT_IO_MASK),
              .INIT_F2('0)) u_io (
      .clk(clk), .rst_n(rst_n),
      .wr_i(wr_ok && kind == K_IO), .sect_i(s_addr[3:2]), .fld_i(s_addr[1:0]),
      .wdata_i(s_wdata), .commit_i(wr_ok && kind == K_IOUPD),
      .rd_data_o(io_rd), .live_o(io_live), .commit_o(io_commit_o)
   );

   for (genvar s = 0; s < MEM_SECTS; s++) begin : g_mem_out
      assign mem_base_o[s*DATA_W +: DATA_W] = mem_live[(s*MEM_FLD+0)*DATA_W +: DATA_W];
      assign mem_mask_o[s*DATA_W +: DATA_W] = mem_live[(s*MEM_FLD+1)*DATA_W +: DATA_W];
      assign mem_phys_o[s*DATA_W +: DATA_W] = mem_live[(s*MEM_FLD+2)*DATA_W +: DATA_W];
   end
   for (genvar s = 0; s < IO_SECTS; s++) begin : g_io_out
      assign io_base_o[s*DATA_W +: DATA_W] = io_live[(s*IO_FLD+0)*DATA_W +: DATA_W];
      assign io_mask_o[s*DATA_W +: DATA_W] = io_live[(s*IO_FLD+1)*DATA_W +: DATA_W];
   end

   irq_unit #(.N(NUM_CORES), .NIRQ(NUM_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .src_i(irq_src_i),
      .wr_i(wr_ok && kind == K_INTEN), .core_i(s_addr[3:1]),
      .wdata_i(s_wdata[NUM_IRQ-1:0]),
      .en_o(en_rd), .pend_o(pend_rd), .core_irq_o(core_irq_o)
   );

   // ---------------- read mux and response ----------------
   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (!err && !s_write) begin
         unique case (kind)
            K_TIME:     rd_val = time_cnt;
            K_TOHOST:   rd_val = tohost_q;
            K_FROMHOST: rd_val = fromhost_q;
            K_MEM:      rd_val = mem_rd;
            K_IO:       rd_val = io_rd;
            K_INTEN:    rd_val[NUM_IRQ-1:0] = en_rd;
            K_INTPEND:  rd_val[NUM_IRQ-1:0] = pend_rd;
            default:    rd_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_o <= '0;
         rsp_rdata_o <= '0;
         rsp_err_o   <= 1'b0;
         rsp_exc_o   <= 1'b0;
         soft_rst_o  <= 1'b0;
         tohost_q    <= '0;
         fromhost_q  <= '0;
      end else begin
         rsp_valid_o <= grant;
         rsp_rdata_o <= rd_val;
         rsp_err_o   <= any_grant && err;
         rsp_exc_o   <= wr_ok && kind == K_FROMHOST && s_wdata != '0;
         soft_rst_o  <= wr_ok && kind == K_RESET;
         if (wr_ok && kind == K_TOHOST)   tohost_q   <= s_wdata;
         if (wr_ok && kind == K_FROMHOST) fromhost_q <= s_wdata;
      end
   end

   a_r1_resp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_valid_o));
   a_r1_resp_to_requester: assert property (@(posedge clk) disable iff (!rst_n)
      any_grant |=> rsp_valid_o == $past(grant));
   a_r9_soft_reset_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(soft_rst_o) |-> $past(any_grant));
   a_r2_no_data_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err_o |-> rsp_rdata_o == '0 && !rsp_exc_o);
endmodule

// File: tb/ctrl_reg_hub_test.sv
module ctrl_reg_hub_test;
   localparam int N  = 4;
   localparam int DW = 64;
   localparam int NI = 64;
   localparam int MS = 4;
   localparam int IS = 4;
   localparam logic [63:0] MBASE = 64'h8000_0000;
   localparam logic [63:0] MMASK = 64'h0FFF_FFFF;
   localparam logic [63:0] MPHYS = 64'h0;
   localparam logic [63:0] IBASE = 64'h6000_0000;
   localparam logic [63:0] IMASK = 64'hFFFF;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [N-1:0]    req_valid = '0, req_write = '0;
   logic [N*12-1:0] req_addr  = '0;
   logic [N*DW-1:0] req_wdata = '0;
   logic [N*2-1:0]  req_priv  = '0;
   logic [NI-1:0]   irq_src   = '0;
   logic [N-1:0]    req_ready, rsp_valid, core_irq;
   logic [DW-1:0]   rsp_rdata, time_value;
   logic            rsp_err, rsp_exc, soft_rst, time_tick, mem_commit, io_commit;
   logic [MS*DW-1:0] mem_base, mem_mask, mem_phys;
   logic [IS*DW-1:0] io_base, io_mask;

   ctrl_reg_hub #(.NUM_CORES(N), .DATA_W(DW), .NUM_IRQ(NI), .MEM_SECTS(MS),
      .IO_SECTS(IS), .TICK_PERIOD(20), .INIT_MEM_BASE(MBASE),
      .INIT_MEM_MASK(MMASK), .INIT_MEM_PHYS(MPHYS), .INIT_IO_BASE(IBASE),
      .INIT_IO_MASK(IMASK)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
      .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .req_priv_i(req_priv), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
      .rsp_err_o(rsp_err), .rsp_exc_o(rsp_exc), .irq_src_i(irq_src),
      .core_irq_o(core_irq), .soft_rst_o(soft_rst), .time_tick_o(time_tick),
      .time_value_o(time_value), .mem_commit_o(mem_commit), .mem_base_o(mem_base),
      .mem_mask_o(mem_mask), .mem_phys_o(mem_phys), .io_commit_o(io_commit),
      .io_base_o(io_base), .io_mask_o(io_mask)
   );

   typedef struct {
      int          core;
      logic [63:0] data;
      bit          err;
      bit          exc;
      bit          chk_d;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   int          checks = 0, errors = 0;
   int          cyc = 0, n_soft = 0, n_mcommit = 0, n_icommit = 0, n_tick = 0;
   int          last_tick_cyc = 0;
   logic [63:0] last_tick_val = '0, last_rdata = '0;
   bit          done = 0;

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic expect_rsp(int c, logic [63:0] d, bit e, bit x, string tag, bit chk_d = 1);
      exp_t it;
      it.core = c; it.data = d; it.err = e; it.exc = x; it.chk_d = chk_d; it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic drive(int c, bit wr, logic [11:0] a, logic [63:0] d, logic [1:0] pv);
      @(negedge clk);
      req_valid[c] = 1'b1;
      req_write[c] = wr;
      req_addr[c*12 +: 12] = a;
      req_wdata[c*DW +: DW] = d;
      req_priv[c*2 +: 2] = pv;
      #1;
      while (!req_ready[c]) begin
         @(negedge clk);
         #1;
      end
      @(negedge clk);
      req_valid[c] = 1'b0;
   endtask

   task automatic xact(int c, bit wr, logic [11:0] a, logic [63:0] d, logic [1:0] pv,
                       logic [63:0] ed, bit ee, bit ex, string tag, bit chk_d = 1);
      expect_rsp(c, ed, ee, ex, tag, chk_d);
      drive(c, wr, a, d, pv);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // scoreboard monitor and pulse counters
   always @(negedge clk) begin
      if (rst_n && !done) begin
         cyc++;
         if (soft_rst)   n_soft++;
         if (mem_commit) n_mcommit++;
         if (io_commit)  n_icommit++;
         if (time_tick) begin
            if (n_tick > 0 && n_tick < 5) begin
               chk(cyc - last_tick_cyc == 20, "R8", "tick spacing",
                   64'(cyc - last_tick_cyc), 64'd20);
               chk(time_value - last_tick_val == 64'd20, "R8", "tick value step",
                   time_value - last_tick_val, 64'd20);
            end
            last_tick_cyc = cyc;
            last_tick_val = time_value;
            n_tick++;
         end
         if (rsp_valid != '0) begin
            if (exp_q.size() == 0) begin
               chk(0, "R1", "unexpected response", 64'(rsp_valid), 64'd0);
            end else begin
               exp_t e;
               int   who;
               e = exp_q.pop_front();
               who = -1;
               for (int i = 0; i < N; i++) if (rsp_valid[i]) who = i;
               chk($onehot(rsp_valid) && who == e.core, "R1",
                   {e.tag, " responding core"}, 64'(rsp_valid), 64'(1 << e.core));
               chk(rsp_err == e.err, e.tag, "error flag", 64'(rsp_err), 64'(e.err));
               chk(rsp_exc == e.exc, e.tag, "exception flag", 64'(rsp_exc), 64'(e.exc));
               if (e.chk_d)
                  chk(rsp_rdata == e.data, e.tag, "read data", rsp_rdata, e.data);
               last_rdata = rsp_rdata;
            end
         end
      end
   end

   task automatic finish_run();
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [63:0] t1, t2;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: reset state at the ports
      chk(mem_base[0 +: DW] == MBASE, "R6", "live mem base 0", mem_base[0 +: DW], MBASE);
      chk(mem_mask[0 +: DW] == MMASK, "R6", "live mem mask 0", mem_mask[0 +: DW], MMASK);
      chk(mem_base[DW +: DW] == 0, "R6", "live mem base 1", mem_base[DW +: DW], 0);
      chk(io_base[0 +: DW] == IBASE, "R6", "live io base 0", io_base[0 +: DW], IBASE);
      chk(io_mask[3*DW +: DW] == 0, "R6", "live io mask 3", io_mask[3*DW +: DW], 0);
      chk(core_irq == 0 && rsp_valid == 0 && !soft_rst, "R6", "idle outputs",
          64'({core_irq, rsp_valid, soft_rst}), 0);
      xact(0, 0, 12'h7a1, 0, 2'b11, MMASK, 0, 0, "R6");
      xact(0, 0, 12'h7b0, 0, 2'b11, IBASE, 0, 0, "R6");
      xact(1, 0, 12'h780, 0, 2'b11, 0, 0, 0, "R6");

      // R10: host pair
      xact(0, 1, 12'h780, 64'h55, 2'b11, 0, 0, 0, "R10");
      xact(0, 0, 12'h780, 0, 2'b11, 64'h55, 0, 0, "R10");
      xact(1, 1, 12'h781, 64'h7, 2'b11, 0, 0, 1, "R10");
      xact(1, 0, 12'h781, 0, 2'b11, 64'h7, 0, 0, "R10");
      xact(1, 1, 12'h781, 64'h0, 2'b11, 0, 0, 0, "R10");

      // R2: non-machine access refused, no state change
      xact(1, 1, 12'h780, 64'h99, 2'b01, 0, 1, 0, "R2");
      xact(2, 0, 12'h780, 0, 2'b00, 0, 1, 0, "R2");
      xact(2, 1, 12'h782, 64'h1, 2'b01, 0, 1, 0, "R2");
      xact(0, 0, 12'h780, 0, 2'b11, 64'h55, 0, 0, "R2");
      wait_idle();
      chk(n_soft == 0, "R2", "soft reset from refused write", n_soft, 0);

      // R3: unmapped and read-only
      xact(3, 1, 12'h7ff, 64'h1, 2'b11, 0, 1, 0, "R3");
      xact(3, 0, 12'h7a3, 0, 2'b11, 0, 1, 0, "R3");
      xact(3, 1, 12'h701, 64'h5, 2'b11, 0, 1, 0, "R3");
      xact(3, 1, 12'h7c1, 64'hF, 2'b11, 0, 1, 0, "R3");
      xact(3, 0, 12'h7c8, 0, 2'b11, 0, 1, 0, "R3");
      xact(3, 1, 12'h7ba, 64'h3, 2'b11, 0, 1, 0, "R3");
      xact(3, 0, 12'h7c0, 0, 2'b11, 0, 0, 0, "R3");

      // R4: staged memory section 1
      xact(0, 1, 12'h7a4, 64'h1000_0000, 2'b11, 0, 0, 0, "R4");
      xact(0, 1, 12'h7a5, 64'hFFFF, 2'b11, 0, 0, 0, "R4");
      xact(0, 1, 12'h7a6, 64'h2000, 2'b11, 0, 0, 0, "R4");
      xact(2, 0, 12'h7a4, 0, 2'b11, 64'h1000_0000, 0, 0, "R4");
      wait_idle();
      chk(mem_base[DW +: DW] == 0 && mem_phys[DW +: DW] == 0, "R4",
          "live map before update", mem_base[DW +: DW], 0);
      chk(n_mcommit == 0, "R4", "commit before update", n_mcommit, 0);
      xact(2, 1, 12'h7af, 64'h1, 2'b11, 0, 0, 0, "R4");
      wait_idle();
      chk(mem_base[DW +: DW] == 64'h1000_0000, "R4", "live base after update",
          mem_base[DW +: DW], 64'h1000_0000);
      chk(mem_mask[DW +: DW] == 64'hFFFF && mem_phys[DW +: DW] == 64'h2000, "R4",
          "live mask/phys after update", mem_phys[DW +: DW], 64'h2000);
      chk(n_mcommit == 1 && n_icommit == 0, "R4", "commit strobe count", n_mcommit, 1);
      xact(2, 0, 12'h7af, 0, 2'b11, 0, 0, 0, "R4");

      // R5: staged I/O section 2
      xact(1, 1, 12'h7b8, 64'h4000_0000, 2'b11, 0, 0, 0, "R5");
      xact(1, 1, 12'h7b9, 64'hFF, 2'b11, 0, 0, 0, "R5");
      xact(1, 0, 12'h7b9, 0, 2'b11, 64'hFF, 0, 0, "R5");
      wait_idle();
      chk(io_base[2*DW +: DW] == 0 && n_icommit == 0, "R5", "live io before update",
          io_base[2*DW +: DW], 0);
      xact(1, 1, 12'h7bf, 64'h0, 2'b11, 0, 0, 0, "R5");
      wait_idle();
      chk(io_base[2*DW +: DW] == 64'h4000_0000 && io_mask[2*DW +: DW] == 64'hFF, "R5",
          "live io after update", io_base[2*DW +: DW], 64'h4000_0000);
      chk(n_icommit == 1, "R5", "io commit count", n_icommit, 1);
      xact(1, 0, 12'h7bf, 0, 2'b11, 0, 0, 0, "R5");

      // R7: interrupts
      irq_src = (64'h1 << 40) | 64'h3;
      xact(2, 1, 12'h7c4, 64'h1_0000_0002, 2'b11, 0, 0, 0, "R7");
      xact(0, 0, 12'h7c5, 0, 2'b11, 64'h2, 0, 0, "R7");
      wait_idle();
      chk(core_irq == 4'b0100, "R7", "core irq lines", 64'(core_irq), 64'h4);
      irq_src = '0;
      repeat (2) @(negedge clk);
      chk(core_irq == 0, "R7", "irq after sources drop", 64'(core_irq), 0);
      xact(2, 0, 12'h7c5, 0, 2'b11, 0, 0, 0, "R7");
      xact(2, 0, 12'h7c4, 0, 2'b11, 64'h1_0000_0002, 0, 0, "R7");

      // R9: soft reset
      xact(3, 1, 12'h782, 64'h1234, 2'b11, 0, 0, 0, "R9");
      wait_idle();
      chk(n_soft == 1, "R9", "soft reset pulses", n_soft, 1);
      xact(3, 0, 12'h782, 0, 2'b11, 0, 0, 0, "R9");

      // R8: live wall clock reads
      xact(0, 0, 12'h701, 0, 2'b11, 0, 0, 0, "R8", 0);
      wait_idle();
      t1 = last_rdata;
      repeat (10) @(negedge clk);
      xact(0, 0, 12'h701, 0, 2'b11, 0, 0, 0, "R8", 0);
      wait_idle();
      t2 = last_rdata;
      chk(t2 > t1 && t2 - t1 >= 10 && t2 - t1 <= 16, "R8", "time read delta", t2 - t1, 12);
      chk(n_tick >= 3, "R8", "ticks seen", n_tick, 3);

      // R1: simultaneous requests after core 0 was last served
      xact(0, 0, 12'h780, 0, 2'b11, 64'h55, 0, 0, "R1");
      wait_idle();
      expect_rsp(1, 64'h1000_0000, 0, 0, "R1");
      expect_rsp(2, 64'h1_0000_0002, 0, 0, "R1");
      expect_rsp(3, MMASK, 0, 0, "R1");
      expect_rsp(0, 64'h55, 0, 0, "R1");
      fork
         drive(0, 0, 12'h780, 0, 2'b11);
         drive(1, 0, 12'h7a4, 0, 2'b11);
         drive(2, 0, 12'h7c4, 0, 2'b11);
         drive(3, 0, 12'h7a1, 0, 2'b11);
      join
      wait_idle();
      chk(exp_q.size() == 0, "R1", "all responses returned", exp_q.size(), 0);

      finish_run();
   end
endmodule